// File: doc/BRIEF.md
# Masked Vector Register Unit

The unit holds a bank of vector registers with a shared active-length register and a per-element mask word. A single command port takes an operation code, three register selectors, an element index and a 64-bit scalar. Register-level commands act right away: set the length, load, clear or read the mask, and write or read one element. Streaming commands walk the elements in order, one per clock, up to the active length. A merge takes each result element from one of two sources, and the mask bit for that element picks which. A test checks one vector against a sign or zero condition and builds a fresh mask word from the outcome, one bit per element.

The mask word is ordered so that its most significant bit belongs to element 0. While a streaming command is in flight the unit reports busy, and it refuses every command that arrives during that time.

Top module: `vmask_unit`

## Requirements
- R1: A command is taken on a rising clock edge when op_valid is 1 and busy is 0. The op_code values are: 0 no operation, 1 set length, 2 load mask, 3 clear mask, 4 read mask, 5 write element, 6 read element, 7 scalar/vector merge, 8 vector/vector merge, 9 test zero, 10 test nonzero, 11 test positive, 12 test negative. Codes 13 to 15 do nothing.
- R2: Set length loads the active length from scalar_in[6:0]. A value above 64 is stored as 64.
- R3: A scalar/vector merge writes, for each element i below the length, scalar_in into register dst_sel when mask bit 63-i is 1, and element i of register srck_sel when that bit is 0.
- R4: A vector/vector merge writes, for each element i below the length, element i of srcj_sel when mask bit 63-i is 1, and element i of srck_sel when it is 0.
- R5: A test evaluates each element i of srcj_sel below the length and writes the outcome to mask bit 63-i. Zero means all bits are 0. Nonzero means at least one bit is 1. Positive means bit 63 is 0, so zero counts as positive. Negative means bit 63 is 1. Every mask bit for an element at or beyond the length ends up 0.
- R6: A merge leaves destination elements at or beyond the length unchanged.
- R7: A streaming command with a nonzero length raises busy from the edge that takes it. It writes one element per clock. It keeps busy high for exactly length+1 cycles, and busy falls on the edge that writes the last element. With a length of 0, busy stays low, a merge writes nothing and a test clears the mask.
- R8: A command presented while busy is 1 has no effect on the registers, the mask, the length or the result outputs.
- R9: Load mask copies scalar_in into the mask, and clear mask sets it to 0. Read mask and read element put their data on result_data and raise result_valid for one cycle after the edge that takes the command.
- R10: Write element stores scalar_in into element elem_idx of register dst_sel. Read element returns element elem_idx of register srcj_sel.
- R11: After reset, busy and result_valid are 0, the length is 0 and the mask is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Command present |
| op_code | input | 4 | Operation code |
| dst_sel | input | 3 | Destination register |
| srcj_sel | input | 3 | First source register |
| srck_sel | input | 3 | Second source register |
| elem_idx | input | 6 | Element index for single-element access |
| scalar_in | input | 64 | Scalar operand |
| busy | output | 1 | Streaming command in flight |
| result_valid | output | 1 | result_data holds a read result |
| result_data | output | 64 | Read result |

## Verification
Results from a read command are registered once, so the bench drives each command on a falling edge and samples result_valid and result_data on the very next falling edge. For a streaming command, the bench counts the falling edges on which busy is high, starting from the first one after the command is taken, and compares the count with length+1 (or 0 when the length is 0). The streamed contents and the new mask are checked only after busy drops: each destination element and the mask word are read back through the command port and compared with a model that the bench rebuilds on its own from the requirements.

// File: rtl/vmu_pkg.sv
package vmu_pkg;

  typedef enum logic [3:0] {
    OP_NOP     = 4'd0,
    OP_SET_VL  = 4'd1,
    OP_SET_VM  = 4'd2,
    OP_CLR_VM  = 4'd3,
    OP_RD_VM   = 4'd4,
    OP_WR_ELEM = 4'd5,
    OP_RD_ELEM = 4'd6,
    OP_MRG_SV  = 4'd7,
    OP_MRG_VV  = 4'd8,
    OP_TST_Z   = 4'd9,
    OP_TST_NZ  = 4'd10,
    OP_TST_POS = 4'd11,
    OP_TST_NEG = 4'd12
  } vmu_op_e;

  function automatic logic op_is_test(vmu_op_e op);
    return (op == OP_TST_Z) || (op == OP_TST_NZ) ||
           (op == OP_TST_POS) || (op == OP_TST_NEG);
  endfunction

  function automatic logic op_is_stream(vmu_op_e op);
    return (op == OP_MRG_SV) || (op == OP_MRG_VV) || op_is_test(op);
  endfunction

  // condition outcome from the two element flags
  function automatic logic cond_hit(vmu_op_e op, logic is_zero, logic is_neg);
    case (op)
      OP_TST_Z:   return is_zero;
      OP_TST_NZ:  return !is_zero;
      OP_TST_POS: return !is_neg;
      OP_TST_NEG: return is_neg;
      default:    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/vmu_regfile.sv
module vmu_regfile #(
  parameter int NREG  = 8,
  parameter int NELEM = 64,
  parameter int W     = 64
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(NREG)-1:0]  wreg,
  input  logic [$clog2(NELEM)-1:0] widx,
  input  logic [W-1:0]             wdata,
  input  logic [$clog2(NREG)-1:0]  ra_reg,
  input  logic [$clog2(NELEM)-1:0] ra_idx,
  output logic [W-1:0]             ra_data,
  input  logic [$clog2(NREG)-1:0]  rb_reg,
  input  logic [$clog2(NELEM)-1:0] rb_idx,
  output logic [W-1:0]             rb_data
);
  localparam int RW    = $clog2(NREG);
  localparam int IW    = $clog2(NELEM);
  localparam int AW    = RW + IW;
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store_q[{wreg, widx}] <= wdata;
  end

  assign ra_data = store_q[{ra_reg, ra_idx}];
  assign rb_data = store_q[{rb_reg, rb_idx}];
endmodule

// File: rtl/vmu_sequencer.sv
module vmu_sequencer #(
  parameter int NELEM = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [$clog2(NELEM+1)-1:0] vl,
  output logic                       active,
  output logic [$clog2(NELEM)-1:0]   idx
);
  localparam int LW = $clog2(NELEM + 1);

  logic at_last;
  assign at_last = (LW'(idx) == vl - LW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
    end else if (start && (vl != '0)) begin
      active <= 1'b1;
      idx    <= '0;
    end else if (active) begin
      if (at_last) active <= 1'b0;
      else         idx    <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/vmu_lane.sv
module vmu_lane
  import vmu_pkg::*;
#(
  parameter int NELEM = 64,
  parameter int W     = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [$clog2(NELEM)-1:0] in_idx,
  input  vmu_op_e                  op,
  input  logic [W-1:0]             src_a,
  input  logic [W-1:0]             src_b,
  input  logic [W-1:0]             scalar,
  input  logic                     mbit,
  output logic                     p_valid,
  output logic [$clog2(NELEM)-1:0] p_idx,
  output logic [W-1:0]             p_data,
  output logic                     p_hit
);
  logic [W-1:0] sel_first;
  logic [W-1:0] merged;
  logic         hit;

  assign sel_first = (op == OP_MRG_SV) ? scalar : src_a;
  assign merged    = mbit ? sel_first : src_b;
  assign hit       = cond_hit(op, (src_a == '0), src_a[W-1]);

  always_ff @(posedge clk) begin
    if (!rst_n) p_valid <= 1'b0;
    else        p_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    p_idx  <= in_idx;
    p_data <= merged;
    p_hit  <= hit;
  end
endmodule

// File: rtl/vmask_unit.sv
module vmask_unit
  import vmu_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int NELEM = 64,
  parameter int W     = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     op_valid,
  input  logic [3:0]               op_code,
  input  logic [$clog2(NREG)-1:0]  dst_sel,
  input  logic [$clog2(NREG)-1:0]  srcj_sel,
  input  logic [$clog2(NREG)-1:0]  srck_sel,
  input  logic [$clog2(NELEM)-1:0] elem_idx,
  input  logic [W-1:0]             scalar_in,
  output logic                     busy,
  output logic                     result_valid,
  output logic [W-1:0]             result_data
);
  localparam int RW = $clog2(NREG);
  localparam int IW = $clog2(NELEM);
  localparam int LW = $clog2(NELEM + 1);
  localparam logic [IW-1:0] TOP_IDX = IW'(NELEM - 1);

  vmu_op_e        op_in, op_q;
  logic [RW-1:0]  dst_q, j_q, k_q;
  logic [W-1:0]   sc_q;
  logic [LW-1:0]  vl_q;
  logic [NELEM-1:0] vm_q;

  // named internal events
  logic           accept, start, seq_active, wr_stream;
  logic [IW-1:0]  issue_idx;
  logic           p_valid, p_hit;
  logic [IW-1:0]  p_idx;
  logic [W-1:0]   p_data;
  logic [W-1:0]   ra_data, rb_data;
  logic           rf_we;
  logic [RW-1:0]  rf_wreg, ra_reg;
  logic [IW-1:0]  rf_widx, ra_idx;
  logic [W-1:0]   rf_wdata;
  logic [LW-1:0]  vl_next;

  assign op_in     = vmu_op_e'(op_code);
  assign busy      = seq_active | p_valid;
  assign accept    = op_valid && !busy;
  assign start     = accept && op_is_stream(op_in);
  assign wr_stream = p_valid;
  assign vl_next   = (scalar_in[LW-1:0] > LW'(NELEM)) ? LW'(NELEM) : scalar_in[LW-1:0];

  vmu_sequencer #(.NELEM(NELEM)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl_q),
    .active(seq_active), .idx(issue_idx)
  );

  assign ra_reg = seq_active ? j_q : srcj_sel;
  assign ra_idx = seq_active ? issue_idx : elem_idx;

  assign rf_we    = (p_valid && !op_is_test(op_q)) || (accept && op_in == OP_WR_ELEM);
  assign rf_wreg  = p_valid ? dst_q  : dst_sel;
  assign rf_widx  = p_valid ? p_idx  : elem_idx;
  assign rf_wdata = p_valid ? p_data : scalar_in;

  vmu_regfile #(.NREG(NREG), .NELEM(NELEM), .W(W)) rf_i (
    .clk(clk), .we(rf_we), .wreg(rf_wreg), .widx(rf_widx), .wdata(rf_wdata),
    .ra_reg(ra_reg), .ra_idx(ra_idx), .ra_data(ra_data),
    .rb_reg(k_q), .rb_idx(issue_idx), .rb_data(rb_data)
  );

  vmu_lane #(.NELEM(NELEM), .W(W)) lane_i (
    .clk(clk), .rst_n(rst_n), .in_valid(seq_active), .in_idx(issue_idx),
    .op(op_q), .src_a(ra_data), .src_b(rb_data), .scalar(sc_q),
    .mbit(vm_q[TOP_IDX - issue_idx]),
    .p_valid(p_valid), .p_idx(p_idx), .p_data(p_data), .p_hit(p_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q  <= OP_NOP;
      dst_q <= '0;
      j_q   <= '0;
      k_q   <= '0;
      sc_q  <= '0;
    end else if (start) begin
      op_q  <= op_in;
      dst_q <= dst_sel;
      j_q   <= srcj_sel;
      k_q   <= srck_sel;
      sc_q  <= scalar_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) vl_q <= '0;
    else if (accept && op_in == OP_SET_VL) vl_q <= vl_next;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vm_q <= '0;
    end else if (accept) begin
      if (op_in == OP_SET_VM) vm_q <= scalar_in[NELEM-1:0];
      else if (op_in == OP_CLR_VM || op_is_test(op_in)) vm_q <= '0;
    end else if (p_valid && op_is_test(op_q)) begin
      vm_q[TOP_IDX - p_idx] <= p_hit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_valid <= 1'b0;
      result_data  <= '0;
    end else begin
      result_valid <= accept && (op_in == OP_RD_VM || op_in == OP_RD_ELEM);
      if (accept && op_in == OP_RD_VM)   result_data <= W'(vm_q);
      if (accept && op_in == OP_RD_ELEM) result_data <= ra_data;
    end
  end
endmodule

// File: rtl/vmask_unit_chk.sv
module vmask_unit_chk #(
  parameter int NELEM = 64
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       busy,
  input logic                       op_valid,
  input logic [$clog2(NELEM+1)-1:0] vl_q,
  input logic                       issue_valid,
  input logic [$clog2(NELEM)-1:0]   issue_idx,
  input logic                       wr_stream,
  input logic                       result_valid
);
  localparam int LW = $clog2(NELEM + 1);

  a_r2_vl_bound: assert property (@(posedge clk) disable iff (!rst_n)
    vl_q <= LW'(NELEM));

  a_r8_vl_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(vl_q));

  a_r7_issue_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> (LW'(issue_idx) < vl_q));

  a_r7_fall_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(wr_stream));

  a_r9_result_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> ($past(op_valid) && !$past(busy)));
endmodule

bind vmask_unit vmask_unit_chk #(.NELEM(NELEM)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .op_valid(op_valid), .vl_q(vl_q),
  .issue_valid(seq_active), .issue_idx(issue_idx), .wr_stream(wr_stream),
  .result_valid(result_valid)
);

// File: tb/vmask_unit_tb_top.sv
`timescale 1ns/1ps
module vmask_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic [2:0]  dst_sel = '0, srcj_sel = '0, srck_sel = '0;
  logic [5:0]  elem_idx = '0;
  logic [63:0] scalar_in = '0;
  logic        busy, result_valid;
  logic [63:0] result_data;

  int checks = 0;
  int failures = 0;

  logic [63:0] mdl [8][64];
  logic [63:0] vm_m;
  int          vl_m;

  always #10 clk = ~clk;

  vmask_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .dst_sel(dst_sel), .srcj_sel(srcj_sel), .srck_sel(srck_sel),
    .elem_idx(elem_idx), .scalar_in(scalar_in), .busy(busy),
    .result_valid(result_valid), .result_data(result_data)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(int code, int d, int j, int k, int idx, logic [63:0] sc);
    @(negedge clk);
    op_valid = 1'b1; op_code = code[3:0]; dst_sel = d[2:0]; srcj_sel = j[2:0];
    srck_sel = k[2:0]; elem_idx = idx[5:0]; scalar_in = sc;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic read_elem(string req, int r, int e);
    drive(6, 0, r, 0, e, 64'd0);
    check(req, {63'd0, result_valid}, 64'd1);
    check(req, result_data, mdl[r][e]);
  endtask

  task automatic read_mask(string req);
    drive(4, 0, 0, 0, 0, 64'd0);
    check(req, {63'd0, result_valid}, 64'd1);
    check(req, result_data, vm_m);
  endtask

  function automatic logic [63:0] pat(int r, int e);
    if (e % 5 == 0) return 64'd0;
    if (e % 3 == 0) return -64'(r * 1000 + e);
    return 64'(r * 1000 + e + 1);
  endfunction

  function automatic logic hit(int c, logic [63:0] d);
    case (c)
      9:  return d == 64'd0;
      10: return d != 64'd0;
      11: return !d[63];
      default: return d[63];
    endcase
  endfunction

  task automatic set_vl(int v);
    drive(1, 0, 0, 0, 0, 64'(v));
    vl_m = (v > 64) ? 64 : v;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    int vls [7] = '{0, 1, 2, 17, 63, 64, 100};
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 busy", {63'd0, busy}, 64'd0);
    check("R11 result_valid", {63'd0, result_valid}, 64'd0);
    rst_n = 1'b1;
    vm_m = 64'd0; vl_m = 0;
    read_mask("R11 mask");
    // R10 fill all registers
    for (int r = 0; r < 8; r++)
      for (int e = 0; e < 64; e++) begin
        mdl[r][e] = pat(r, e);
        drive(5, r, 0, 0, e, mdl[r][e]);
      end
    for (int e = 0; e < 64; e += 7) read_elem("R10 readback", 3, e);
    // R11/R7 length 0 after reset: merge does nothing, never busy
    drive(2, 0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF); vm_m = '1;
    drive(8, 6, 1, 2, 0, 64'd0);
    wait_idle(n);
    check("R7 zero length busy", 64'(n), 64'd0);
    for (int e = 0; e < 64; e += 9) read_elem("R11 length zero", 6, e);

    foreach (vls[t]) begin
      int v = vls[t];
      int j = v % 8;
      set_vl(v);
      for (int c = 9; c <= 12; c++) begin
        drive(2, 0, 0, 0, 0, 64'hFFFF_0000_FFFF_0000); // stale mask
        drive(c, 0, j, 0, 0, 64'd0);
        wait_idle(n);
        check("R7 busy cycles", 64'(n), 64'(vl_m > 0 ? vl_m + 1 : 0));
        vm_m = 64'd0;
        for (int i = 0; i < vl_m; i++) vm_m[63 - i] = hit(c, mdl[j][i]);
        read_mask("R5 test mask");
      end
      // R9 load mask
      vm_m = 64'hA5C3_1E7F_0F0F_9B2D ^ {8{8'(v)}};
      drive(2, 0, 0, 0, 0, vm_m);
      read_mask("R9 load mask");
      // R3 scalar/vector merge
      begin
        int k = (v + 1) % 6;
        logic [63:0] sc = 64'hDEAD_BEEF_0000_0000 + 64'(v);
        drive(7, 6, 0, k, 0, sc);
        wait_idle(n);
        check("R7 busy cycles merge", 64'(n), 64'(vl_m > 0 ? vl_m + 1 : 0));
        for (int i = 0; i < vl_m; i++) mdl[6][i] = vm_m[63 - i] ? sc : mdl[k][i];
        for (int i = 0; i < 64; i++) read_elem(i < vl_m ? "R3 merge sv" : "R6 tail sv", 6, i);
      end
      // R4 vector/vector merge
      drive(8, 7, 1, 2, 0, 64'd0);
      wait_idle(n);
      for (int i = 0; i < vl_m; i++) mdl[7][i] = vm_m[63 - i] ? mdl[1][i] : mdl[2][i];
      for (int i = 0; i < 64; i++) read_elem(i < vl_m ? "R4 merge vv" : "R6 tail vv", 7, i);
    end
    // R2 saturation: last pass used 100 -> 64 elements, busy 65 checked above
    set_vl(127);
    drive(8, 5, 1, 2, 0, 64'd0);
    wait_idle(n);
    check("R2 saturate busy", 64'(n), 64'd65);
    for (int i = 0; i < 64; i++) mdl[5][i] = vm_m[63 - i] ? mdl[1][i] : mdl[2][i];
    read_elem("R2 last element", 5, 63);
    // R8 refused commands while busy
    drive(8, 6, 1, 2, 0, 64'd0);
    check("R8 busy", {63'd0, busy}, 64'd1);
    drive(2, 0, 0, 0, 0, 64'h1234_5678_9ABC_DEF0);
    drive(5, 4, 0, 0, 5, 64'h5555_5555_5555_5555);
    drive(4, 0, 0, 0, 0, 64'd0);
    check("R8 no read result", {63'd0, result_valid}, 64'd0);
    drive(1, 0, 0, 0, 0, 64'd3);
    wait_idle(n);
    for (int i = 0; i < 64; i++) mdl[6][i] = vm_m[63 - i] ? mdl[1][i] : mdl[2][i];
    read_mask("R8 mask kept");
    read_elem("R8 element kept", 4, 5);
    drive(8, 0, 1, 2, 0, 64'd0);
    wait_idle(n);
    check("R8 length kept", 64'(n), 64'd65);
    for (int i = 0; i < 64; i++) mdl[0][i] = vm_m[63 - i] ? mdl[1][i] : mdl[2][i];
    read_elem("R8 merge after", 0, 40);
    // R1 undefined code does nothing; R9 clear mask
    drive(14, 3, 0, 0, 0, 64'hFFFF);
    check("R1 no result", {63'd0, result_valid}, 64'd0);
    check("R1 not busy", {63'd0, busy}, 64'd0);
    read_mask("R1 mask kept");
    drive(3, 0, 0, 0, 0, 64'd0); vm_m = 64'd0;
    read_mask("R9 clear mask");
    // R7 zero-length test clears mask
    drive(2, 0, 0, 0, 0, 64'hF0F0); set_vl(0);
    drive(9, 0, 1, 0, 0, 64'd0);
    wait_idle(n);
    check("R7 zero test busy", 64'(n), 64'd0);
    vm_m = 64'd0;
    read_mask("R7 zero test mask");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule